// File: doc/BRIEF.md
# Padded Coordinate Mapper

This block places a layer rectangle into a frame whose rows follow a repeating pattern: a group of real (active) rows, then a group of filler (dummy) rows, then again. Given the active group size `m`, the filler group size `d` (pattern period `n = m + d`), and a rectangle's top row `y` and row count `h`, all expressed in unpadded coordinates, it returns where the rectangle lands in the padded frame. The outputs are the padded top row, how many active rows the rectangle has before it first meets a filler group, and how many padded rows it spans in total, fillers included.

The unit is a start/done sequencer. A `start` pulse while idle captures the four inputs. One shared restoring divider then runs twice: first on `y`, then on the last source row `L = y + h - 1`, each time by `m`. Quotients and remainders are combined with `n` into registered results, and `done` pulses for one cycle. A zero active size or a zero height is rejected at once with a flag, and the previous results stay in place.

Top module: `pad_map`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done`, both error flags, `y_pad`, `first_act` and `h_pad` are all zero.
- R2: After a valid request, `y_pad` equals `(y mod m) + (y div m) * (m + d)`.
- R3: After a valid request, `first_act` equals `m - (y mod m)`, a value in the range 1 to m.
- R4: After a valid request, with `L = y + h - 1` and `E = (L div m) * (m + d) + (L mod m)`, `h_pad` equals `E - y_pad + 1`.
- R5: A request with `act_cnt` of zero completes with `done` in the cycle after `start`, sets `err_m_zero`, and leaves `y_pad`, `first_act` and `h_pad` unchanged.
- R6: A request with `h_in` of zero completes with `done` in the cycle after `start`, sets `err_h_zero`, and leaves the three results unchanged. Both flags are set together when both inputs are zero.
- R7: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after an accepted valid request until `done`. Results and flags change only in the `done` cycle and are held until the next one.
- R8: A `start` pulse while `busy` is high is ignored. The running request finishes with results from its own captured inputs.
- R9: With `d = 0` the mapping is the identity: `y_pad = y` and `h_pad = h`.
- R10: `done` follows an accepted valid request within `2*(W+1)+10` clock cycles.
- R11: All-ones 16-bit inputs produce exact results with no overflow. Result outputs are `2*W+2` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| act_cnt | input | W | Active rows per pattern period (m) |
| dum_cnt | input | W | Filler rows per pattern period (d) |
| y_in | input | W | Rectangle top row, unpadded |
| h_in | input | W | Rectangle height in rows, unpadded |
| busy | output | 1 | A valid request is being computed |
| done | output | 1 | One-cycle completion pulse |
| err_m_zero | output | 1 | Last request had a zero active size |
| err_h_zero | output | 1 | Last request had a zero height |
| y_pad | output | 2*W+2 | Padded top row |
| first_act | output | W | Active rows before the first filler group |
| h_pad | output | 2*W+2 | Padded height in rows |

## Verification
The bench builds the block with the default `W = 16`. At that width both division passes take a full 17-step run, so the latency bound is exercised at its real size. The all-ones corner is reachable: `y + h - 1` needs the extra dividend bit, and the quotient-times-period product needs the full result width. Small and mid-sized patterns, including ratios near 93:45, cover remainders that cross group boundaries at the top and bottom of the rectangle.

// File: rtl/pad_map_pkg.sv
package pad_map_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH_Y,
    ST_WAIT_Y,
    ST_LAUNCH_L,
    ST_WAIT_L,
    ST_CALC
  } pm_state_e;
endpackage

// File: rtl/pad_map_div.sv
// Restoring divider, one quotient bit per cycle, valid pulse after NW steps.
module pad_map_div #(
  parameter int NW = 17,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] dvd,
  input  logic [DW-1:0] dvs,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          valid
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] quo_q, quo_nx;
  logic [DW-1:0] rem_q, rem_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          val_q, val_nx;
  logic [DW:0]   shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[NW-1]};
    diff    = shifted - {1'b0, dvs};
    fits    = (shifted >= {1'b0, dvs});
    quo_nx  = quo_q;
    rem_nx  = rem_q;
    cnt_nx  = cnt_q;
    val_nx  = 1'b0;
    if (go) begin
      quo_nx = dvd;
      rem_nx = '0;
      cnt_nx = CW'(NW);
    end else if (cnt_q != '0) begin
      quo_nx = {quo_q[NW-2:0], fits};
      rem_nx = fits ? diff[DW-1:0] : shifted[DW-1:0];
      cnt_nx = cnt_q - CW'(1);
      val_nx = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      val_q <= 1'b0;
    end else begin
      quo_q <= quo_nx;
      rem_q <= rem_nx;
      cnt_q <= cnt_nx;
      val_q <= val_nx;
    end
  end

  assign quo   = quo_q;
  assign rem   = rem_q;
  assign valid = val_q;
endmodule

// File: rtl/pad_map_seq.sv
// Sequencer: capture, two divider passes, result write.
module pad_map_seq
  import pad_map_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bad,
  input  logic div_valid,
  output logic ld_in,
  output logic div_go,
  output logic sel_l,
  output logic cap_y,
  output logic cap_l,
  output logic fin_ok,
  output logic fin_err,
  output logic busy
);
  pm_state_e st_q, st_nx;

  always_comb begin
    st_nx   = st_q;
    ld_in   = 1'b0;
    div_go  = 1'b0;
    sel_l   = 1'b0;
    cap_y   = 1'b0;
    cap_l   = 1'b0;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        ld_in = 1'b1;
        if (bad) fin_err = 1'b1;
        else     st_nx   = ST_LAUNCH_Y;
      end
      ST_LAUNCH_Y: begin
        div_go = 1'b1;
        st_nx  = ST_WAIT_Y;
      end
      ST_WAIT_Y: if (div_valid) begin
        cap_y = 1'b1;
        st_nx = ST_LAUNCH_L;
      end
      ST_LAUNCH_L: begin
        div_go = 1'b1;
        sel_l  = 1'b1;
        st_nx  = ST_WAIT_L;
      end
      ST_WAIT_L: begin
        sel_l = 1'b1;
        if (div_valid) begin
          cap_l = 1'b1;
          st_nx = ST_CALC;
        end
      end
      ST_CALC: begin
        fin_ok = 1'b1;
        st_nx  = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nx;
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/pad_map.sv
module pad_map #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [W-1:0]    act_cnt,
  input  logic [W-1:0]    dum_cnt,
  input  logic [W-1:0]    y_in,
  input  logic [W-1:0]    h_in,
  output logic            busy,
  output logic            done,
  output logic            err_m_zero,
  output logic            err_h_zero,
  output logic [2*W+1:0]  y_pad,
  output logic [W-1:0]    first_act,
  output logic [2*W+1:0]  h_pad
);
  localparam int NW = W + 1;
  localparam int OW = 2 * W + 2;

  logic          ld_in, div_go, sel_l, cap_y, cap_l, fin_ok, fin_err;
  logic          bad, div_valid;
  logic [W-1:0]  m_q, d_q, y_q, h_q;
  logic [NW-1:0] qy_q, ql_q, div_q, dvd;
  logic [W-1:0]  ry_q, rl_q, div_r;
  logic [NW-1:0] period, last_row;
  logic [OW-1:0] ys_calc, ye_calc, hp_calc;
  logic [W-1:0]  fa_calc;
  logic [OW-1:0] y_pad_q, h_pad_q;
  logic [W-1:0]  fa_q;
  logic          em_q, eh_q, done_q;

  assign bad = (act_cnt == '0) || (h_in == '0);

  pad_map_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bad(bad), .div_valid(div_valid),
    .ld_in(ld_in), .div_go(div_go), .sel_l(sel_l), .cap_y(cap_y), .cap_l(cap_l),
    .fin_ok(fin_ok), .fin_err(fin_err), .busy(busy)
  );

  always_comb begin
    period   = NW'(m_q) + NW'(d_q);
    last_row = NW'(y_q) + NW'(h_q) - NW'(1);
    dvd      = sel_l ? last_row : NW'(y_q);
    ys_calc  = OW'(qy_q) * OW'(period) + OW'(ry_q);
    ye_calc  = OW'(ql_q) * OW'(period) + OW'(rl_q);
    hp_calc  = ye_calc - ys_calc + OW'(1);
    fa_calc  = m_q - ry_q;
  end

  pad_map_div #(.NW(NW), .DW(W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dvd(dvd), .dvs(m_q),
    .quo(div_q), .rem(div_r), .valid(div_valid)
  );

  // Captured request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0; d_q <= '0; y_q <= '0; h_q <= '0;
    end else if (ld_in) begin
      m_q <= act_cnt; d_q <= dum_cnt; y_q <= y_in; h_q <= h_in;
    end
  end

  // Division results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qy_q <= '0; ry_q <= '0;
    end else if (cap_y) begin
      qy_q <= div_q; ry_q <= div_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ql_q <= '0; rl_q <= '0;
    end else if (cap_l) begin
      ql_q <= div_q; rl_q <= div_r;
    end
  end

  // Result registers, written only on a good finish
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_pad_q <= '0; h_pad_q <= '0; fa_q <= '0;
    end else if (fin_ok) begin
      y_pad_q <= ys_calc; h_pad_q <= hp_calc; fa_q <= fa_calc;
    end
  end

  // Flags, written at either finish
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em_q <= 1'b0; eh_q <= 1'b0;
    end else if (fin_ok || fin_err) begin
      em_q <= fin_err && (act_cnt == '0);
      eh_q <= fin_err && (h_in == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fin_ok || fin_err;
  end

  assign done       = done_q;
  assign err_m_zero = em_q;
  assign err_h_zero = eh_q;
  assign y_pad      = y_pad_q;
  assign h_pad      = h_pad_q;
  assign first_act  = fa_q;
endmodule

// File: rtl/pad_map_chk.sv
module pad_map_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   act_cnt,
  input logic [W-1:0]   h_in,
  input logic           busy,
  input logic           done,
  input logic           err_m_zero,
  input logic           err_h_zero,
  input logic [2*W+1:0] y_pad,
  input logic [W-1:0]   first_act,
  input logic [2*W+1:0] h_pad
);
  localparam int LIM = 2 * (W + 1) + 10;
  localparam int LW  = $clog2(LIM + 2);

  logic [W-1:0]  m_cap, h_cap;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cap <= '0; h_cap <= '0;
    end else if (start && !busy) begin
      m_cap <= act_cnt; h_cap <= h_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_q <= '0;
    else if (!busy)          lat_q <= '0;
    else if (lat_q != '1)    lat_q <= lat_q + LW'(1);
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(y_pad) && $stable(h_pad) && $stable(first_act)
               && $stable(err_m_zero) && $stable(err_h_zero)));
  a_r5_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_m_zero || err_h_zero)) |->
      ($stable(y_pad) && $stable(h_pad) && $stable(first_act)));
  a_r5_m_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_m_zero == (m_cap == '0)));
  a_r6_h_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_h_zero == (h_cap == '0)));
  a_r3_first_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_m_zero && !err_h_zero) |->
      (first_act != '0 && first_act <= m_cap));
  a_r4_height_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_m_zero && !err_h_zero) |-> (h_pad >= (2*W+2)'(h_cap)));
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_q <= LW'(LIM)));
endmodule

bind pad_map pad_map_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .act_cnt(act_cnt), .h_in(h_in),
  .busy(busy), .done(done), .err_m_zero(err_m_zero), .err_h_zero(err_h_zero),
  .y_pad(y_pad), .first_act(first_act), .h_pad(h_pad)
);

// File: tb/pad_map_bench.sv
module pad_map_bench;
  localparam int  W     = 16;
  localparam int  OW    = 2 * W + 2;
  localparam time CLK_P = 10ns;
  localparam int  LIM   = 2 * (W + 1) + 10;

  logic          clk, rst_n, start;
  logic [W-1:0]  act_cnt, dum_cnt, y_in, h_in;
  logic          busy, done, err_m_zero, err_h_zero;
  logic [OW-1:0] y_pad, h_pad;
  logic [W-1:0]  first_act;

  int n_chk  = 0;
  int n_fail = 0;

  pad_map #(.W(W)) u_pad_map (
    .clk(clk), .rst_n(rst_n), .start(start), .act_cnt(act_cnt), .dum_cnt(dum_cnt),
    .y_in(y_in), .h_in(h_in), .busy(busy), .done(done), .err_m_zero(err_m_zero),
    .err_h_zero(err_h_zero), .y_pad(y_pad), .first_act(first_act), .h_pad(h_pad)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one request; returns cycles until done (-1 if none seen)
  task automatic issue(input int m, input int d, input int y, input int h, output int lat);
    @(negedge clk);
    act_cnt = W'(m); dum_cnt = W'(d); y_in = W'(y); h_in = W'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = -1;
    for (int i = 1; i <= LIM + 20; i++) begin
      if (done) begin lat = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic expect_map(input int m, input int d, input int y, input int h);
    longint n, ys, fa, l, ye, hp;
    int lat;
    n  = longint'(m) + d;
    ys = (y % m) + (y / m) * n;
    fa = m - (y % m);
    l  = longint'(y) + h - 1;
    ye = (l / m) * n + (l % m);
    hp = ye - ys + 1;
    issue(m, d, y, h, lat);
    chk(lat > 0 && lat <= LIM, "R10 latency", lat, LIM);
    chk(longint'(y_pad) == ys, "R2 y_pad", longint'(y_pad), ys);
    chk(longint'(first_act) == fa, "R3 first_act", longint'(first_act), fa);
    chk(longint'(h_pad) == hp, "R4 h_pad", longint'(h_pad), hp);
    chk(!err_m_zero && !err_h_zero, "R7 flags clear", {err_m_zero, err_h_zero}, 0);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0;
    act_cnt = '0; dum_cnt = '0; y_in = '0; h_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err_m_zero && !err_h_zero, "R1 ctrl in reset",
        {busy, done, err_m_zero, err_h_zero}, 0);
    chk(y_pad == '0 && h_pad == '0 && first_act == '0, "R1 results in reset",
        longint'(y_pad) + longint'(h_pad) + longint'(first_act), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && y_pad == '0, "R1 after release", {busy, done}, 0);
  endtask

  task automatic t_patterns;
    expect_map(3, 1, 0, 6);
    expect_map(5, 2, 7, 4);
    expect_map(4, 4, 3, 1);
    expect_map(93, 45, 100, 500);
    expect_map(2, 3, 9, 9);
  endtask

  task automatic t_identity; // R9
    expect_map(7, 0, 13, 20);
    chk(y_pad == OW'(13) && h_pad == OW'(20), "R9 identity",
        longint'(h_pad), 20);
  endtask

  task automatic t_wide; // R11
    expect_map(65535, 65535, 65535, 65535);
    expect_map(1, 65535, 65535, 65535);
  endtask

  task automatic t_errors;
    logic [OW-1:0] yp, hp;
    logic [W-1:0]  fa;
    int lat;
    expect_map(6, 2, 11, 5);
    yp = y_pad; hp = h_pad; fa = first_act;
    issue(0, 3, 4, 4, lat);
    chk(lat == 1, "R5 zero m done timing", lat, 1);
    chk(err_m_zero && !err_h_zero, "R5 zero m flag", {err_m_zero, err_h_zero}, 2);
    chk(y_pad == yp && h_pad == hp && first_act == fa, "R5 results held",
        longint'(y_pad), longint'(yp));
    issue(4, 3, 4, 0, lat);
    chk(lat == 1, "R6 zero h done timing", lat, 1);
    chk(!err_m_zero && err_h_zero, "R6 zero h flag", {err_m_zero, err_h_zero}, 1);
    chk(y_pad == yp && h_pad == hp && first_act == fa, "R6 results held",
        longint'(h_pad), longint'(hp));
    issue(0, 0, 0, 0, lat);
    chk(err_m_zero && err_h_zero, "R6 both flags", {err_m_zero, err_h_zero}, 3);
    repeat (5) @(negedge clk);
    chk(err_m_zero && err_h_zero && y_pad == yp, "R7 held idle",
        {err_m_zero, err_h_zero}, 3);
  endtask

  task automatic t_busy_start; // R8
    int lat;
    @(negedge clk);
    act_cnt = W'(3); dum_cnt = W'(2); y_in = W'(10); h_in = W'(7); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R7 busy after accept", busy, 1);
    repeat (3) @(negedge clk);
    act_cnt = W'(0); dum_cnt = W'(9); y_in = W'(1); h_in = W'(1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = -1;
    for (int i = 0; i < LIM + 20; i++) begin
      if (done) begin lat = i; break; end
      @(negedge clk);
    end
    // 10 = 3*3+1 -> ys = 1 + 3*5 = 16; L = 16 = 5*3+1 -> ye = 26; hp = 11
    chk(lat >= 0, "R8 finished", lat, 0);
    chk(!err_m_zero, "R8 ignored start flag", err_m_zero, 0);
    chk(y_pad == OW'(16), "R8 y_pad", longint'(y_pad), 16);
    chk(h_pad == OW'(11), "R8 h_pad", longint'(h_pad), 11);
    chk(first_act == W'(2), "R8 first_act", longint'(first_act), 2);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_patterns();
    t_identity();
    t_wide();
    t_errors();
    t_busy_start();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule